// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

This unit moves one vector from an interleaved word memory into a vector register. A start command supplies a base word address, a signed word stride and a vector length. The unit then walks the elements in index order. For element k it forms the word address base + k × stride and sends it to the bank named by the low address bits. It never exceeds the bank recovery time: a bank that has just taken a request stays unavailable for a fixed number of cycles. Issue waits whenever the next element's bank is still recovering.

The memory returns each word a fixed number of cycles after its request. The unit carries each element's index alongside the request through a matching delay line. Each returned word is therefore presented on the element write port together with the register slot it belongs to. A one-cycle done pulse marks the write of the last element. A zero-length command completes at once and touches no bank.

The default configuration has 16 banks of 64-bit words, a bank recovery time of 4 cycles, a memory latency of 12 cycles and a maximum vector length of 64.

Top module: `vec_strided_load`

## Requirements
- R1: A start is accepted only while `busy_o` is low; for a nonzero length `busy_o` is high from the next cycle. A start raised while `busy_o` is high has no effect on the running transfer.
- R2: Element k is requested at word address base + k × stride, where the stride is a two's complement word count and the sum wraps modulo 2^AW. Requests are made in increasing k, at most one per cycle.
- R3: `req_bank_o` equals the request's word address modulo 16, which is its four low bits.
- R4: After a bank receives a request in cycle c, it receives no further request before cycle c+4.
- R5: When the next element's bank is free, that element is requested in the same cycle. A unit-stride transfer therefore issues one element per cycle with no bubbles.
- R6: With a stride that is a multiple of 16 (including 0), every element goes to one bank, and consecutive requests are exactly 4 cycles apart.
- R7: Data for a request made in cycle c is taken from `rsp_data_i` in cycle c+12. In that same cycle it is presented with `wr_en_o` high and `wr_idx_o` equal to that element's index.
- R8: `done_o` is high for one cycle, the cycle after the last element is written. `busy_o` is low in that cycle.
- R9: A start with length 0 makes no request and raises `done_o` in the cycle after the start.
- R10: A length above 64 is treated as 64.
- R11: After reset, `busy_o`, `done_o`, `req_valid_o` and `wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command |
| base_i | input | 32 | Base word address |
| stride_i | input | 32 | Signed stride in words |
| vlen_i | input | 7 | Vector length (0 to 127, clamped to 64) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_valid_o | output | 1 | Bank request this cycle |
| req_bank_o | output | 4 | Bank index of the request |
| req_addr_o | output | 32 | Word address of the request |
| rsp_data_i | input | 64 | Memory data, due 12 cycles after its request |
| wr_en_o | output | 1 | Element write enable |
| wr_idx_o | output | 6 | Element index in the vector register |
| wr_data_o | output | 64 | Element data |

## Verification
The checker watches several rules on every cycle:
- the per-bank recovery spacing;
- the fixed gap between each request and its write;
- the address step from the captured base and stride;
- silence while idle;
- the idle state at the done pulse.

Other properties need whole scenarios and are shown only by the bench:
- exact completion cycles, which depend on stride-driven bank conflicts;
- the one-request-per-cycle rate for unit stride;
- length clamping;
- zero-length completion;
- that a start raised mid-transfer is ignored;
- that every register slot receives the right word exactly once.

// File: rtl/vec_strided_load.sv
module vec_strided_load #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int MAXVL = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [AW-1:0]               base_i,
  input  logic [AW-1:0]               stride_i,
  input  logic [$clog2(MAXVL+1)-1:0]  vlen_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        req_valid_o,
  output logic [$clog2(NBANK)-1:0]    req_bank_o,
  output logic [AW-1:0]               req_addr_o,
  input  logic [DW-1:0]               rsp_data_i,
  output logic                        wr_en_o,
  output logic [$clog2(MAXVL)-1:0]    wr_idx_o,
  output logic [DW-1:0]               wr_data_o
);
  localparam int BW  = $clog2(NBANK);
  localparam int IW  = $clog2(MAXVL);
  localparam int VLW = $clog2(MAXVL+1);
  localparam int CW  = $clog2(BUSY+1);

  logic           active;
  logic [VLW-1:0] len_q, iss_cnt;
  logic [AW-1:0]  addr_q, stride_q;
  logic [CW-1:0]  bank_cnt [NBANK];
  logic [LAT-1:0] pv;
  logic [IW-1:0]  pidx [LAT];

  wire [BW-1:0]  bank     = addr_q[BW-1:0];
  wire           accept   = start_i && !active;
  wire [VLW-1:0] vl_clamp = (vlen_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen_i;
  wire           last_wr  = wr_en_o && (wr_idx_o == IW'(len_q - VLW'(1)));

  assign req_valid_o = active && (iss_cnt < len_q) && (bank_cnt[bank] == '0);
  assign req_bank_o  = bank;
  assign req_addr_o  = addr_q;
  assign busy_o      = active;
  assign wr_en_o     = pv[LAT-1];
  assign wr_idx_o    = pidx[LAT-1];
  assign wr_data_o   = rsp_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done_o   <= 1'b0;
      len_q    <= '0;
      iss_cnt  <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      pv       <= '0;
      for (int b = 0; b < NBANK; b++) bank_cnt[b] <= '0;
      for (int k = 0; k < LAT; k++)   pidx[k]     <= '0;
    end else begin
      done_o <= (accept && vl_clamp == '0) || last_wr;
      if (accept && vl_clamp != '0) begin
        active   <= 1'b1;
        len_q    <= vl_clamp;
        iss_cnt  <= '0;
        addr_q   <= base_i;
        stride_q <= stride_i;
      end else begin
        if (last_wr) active <= 1'b0;
        if (req_valid_o) begin
          iss_cnt <= iss_cnt + VLW'(1);
          addr_q  <= addr_q + stride_q;
        end
      end
      for (int b = 0; b < NBANK; b++) begin
        if (req_valid_o && bank == BW'(b)) bank_cnt[b] <= CW'(BUSY - 1);
        else if (bank_cnt[b] != '0)        bank_cnt[b] <= bank_cnt[b] - CW'(1);
      end
      pv      <= {pv[LAT-2:0], req_valid_o};
      pidx[0] <= iss_cnt[IW-1:0];
      for (int k = 1; k < LAT; k++) pidx[k] <= pidx[k-1];
    end
  end
endmodule

// File: rtl/vec_strided_load_chk.sv
module vec_strided_load_chk #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int MAXVL = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic [AW-1:0]              base_i,
  input logic [AW-1:0]              stride_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic                       req_valid_o,
  input logic [$clog2(NBANK)-1:0]   req_bank_o,
  input logic [AW-1:0]              req_addr_o,
  input logic                       wr_en_o
);
  localparam int CW = $clog2(BUSY+1);

  logic [CW-1:0]  gap [NBANK];
  logic [LAT-1:0] sh;
  logic           have_prev;
  logic [AW-1:0]  prev_addr, base_c, stride_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) gap[b] <= CW'(BUSY);
      sh        <= '0;
      have_prev <= 1'b0;
      prev_addr <= '0;
      base_c    <= '0;
      stride_c  <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (req_valid_o && req_bank_o == $clog2(NBANK)'(b)) gap[b] <= CW'(1);
        else if (gap[b] < CW'(BUSY))                        gap[b] <= gap[b] + CW'(1);
      end
      sh <= {sh[LAT-2:0], req_valid_o};
      if (start_i && !busy_o) begin
        have_prev <= 1'b0;
        base_c    <= base_i;
        stride_c  <= stride_i;
      end else if (req_valid_o) begin
        have_prev <= 1'b1;
        prev_addr <= req_addr_o;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    p_bank_recover_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_bank_o == $clog2(NBANK)'(b)) |-> gap[b] >= CW'(BUSY));
  end

  p_write_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o == sh[LAT-1]);

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !have_prev) |-> req_addr_o == base_c);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && have_prev) |-> req_addr_o == prev_addr + stride_c);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind vec_strided_load vec_strided_load_chk #(
  .AW(AW), .DW(DW), .NBANK(NBANK), .BUSY(BUSY), .LAT(LAT), .MAXVL(MAXVL)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .stride_i(stride_i),
  .busy_o(busy_o), .done_o(done_o), .req_valid_o(req_valid_o), .req_bank_o(req_bank_o),
  .req_addr_o(req_addr_o), .wr_en_o(wr_en_o)
);

// File: tb/test_vec_strided_load.sv
module test_vec_strided_load;
  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0, stride_i = '0;
  logic [6:0]  vlen_i = '0;
  logic        busy_o, done_o, req_valid_o, wr_en_o;
  logic [3:0]  req_bank_o;
  logic [31:0] req_addr_o;
  logic [63:0] rsp_data_i, wr_data_o;
  logic [5:0]  wr_idx_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [63:0] mem_pipe [LAT];

  always #4 clk = ~clk;

  vec_strided_load i_vec_strided_load (.*);

  function automatic logic [63:0] mem_word(logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_pipe[0] <= req_valid_o ? mem_word(req_addr_o) : 64'h0;
    for (int k = 1; k < LAT; k++) mem_pipe[k] <= mem_pipe[k-1];
  end
  assign rsp_data_i = mem_pipe[LAT-1];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_done(logic [31:0] base, logic [31:0] stride, int vl);
    int t = 1, last = 0;
    int fr [16];
    for (int b = 0; b < 16; b++) fr[b] = 0;
    if (vl > 64) vl = 64;
    if (vl == 0) return 1;
    for (int k = 0; k < vl; k++) begin
      logic [31:0] a = base + 32'(k) * stride;
      if (t < fr[a[3:0]]) t = fr[a[3:0]];
      fr[a[3:0]] = t + 4;
      last = t;
      t++;
    end
    return last + LAT + 1;
  endfunction

  task automatic run_op(logic [31:0] base, logic [31:0] stride, int vlen, bit poke);
    int vl = (vlen > 64) ? 64 : vlen;
    int s, k = 0, nw = 0, n = 0, last_req = -1, dcyc = -1;
    bit seen [64];
    bit mult16 = (stride[3:0] == 4'h0);
    for (int i = 0; i < 64; i++) seen[i] = 0;
    @(negedge clk);
    start_i = 1; base_i = base; stride_i = stride; vlen_i = 7'(vlen);
    s = cyc;
    @(negedge clk);
    start_i = 0; base_i = 32'hDEAD_0000; stride_i = 32'd5; vlen_i = 7'd3;
    if (vl > 0) chk(busy_o, "R1", "busy after start", busy_o, 1);
    while (dcyc < 0 && n < 3000) begin
      if (done_o) begin
        dcyc = cyc - s;
        chk(!busy_o, "R8", "busy at done", busy_o, 0);
      end
      if (req_valid_o) begin
        logic [31:0] ea = base + 32'(k) * stride;
        chk(req_addr_o == ea, "R2", "request address", req_addr_o, ea);
        chk(req_bank_o == req_addr_o[3:0], "R3", "bank index", req_bank_o, req_addr_o[3:0]);
        if (mult16 && last_req >= 0)
          chk(cyc - last_req == 4, "R6", "same-bank spacing", cyc - last_req, 4);
        last_req = cyc;
        k++;
      end
      if (wr_en_o) begin
        logic [63:0] ed = mem_word(base + 32'(wr_idx_o) * stride);
        chk(wr_data_o == ed, "R7", "element data", wr_data_o, ed);
        chk(!seen[wr_idx_o] && int'(wr_idx_o) < vl, "R7", "element index", wr_idx_o, vl);
        seen[wr_idx_o] = 1;
        nw++;
      end
      if (poke && n == 3) begin
        start_i = 1; vlen_i = 7'd2; base_i = 32'h0BAD_0000;
      end else start_i = 0;
      @(negedge clk);
      n++;
    end
    start_i = 0;
    chk(dcyc == exp_done(base, stride, vlen), vl == 0 ? "R9" : (mult16 ? "R6" : "R5"),
        "completion cycle", dcyc, exp_done(base, stride, vlen));
    chk(k == vl, vlen > 64 ? "R10" : "R2", "request count", k, vl);
    chk(nw == vl, "R7", "write count", nw, vl);
    @(negedge clk);
    chk(!done_o, "R8", "done single cycle", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !req_valid_o && !wr_en_o, "R11", "reset outputs",
        {busy_o, done_o, req_valid_o, wr_en_o}, 0);
    run_op(32'h100, 32'd1, 64, 0);          // R5 unit stride
    run_op(32'h203, 32'd16, 10, 0);         // R6
    run_op(32'h40, 32'd0, 6, 0);            // R6 stride zero
    run_op(32'h10, 32'hFFFF_FFFF, 20, 0);   // R2 negative stride
    run_op(32'h0, 32'd8, 16, 0);            // R4 two banks
    run_op(32'h55, 32'd3, 0, 0);            // R9
    run_op(32'h77, 32'd1, 100, 0);          // R10
    run_op(32'h9, 32'd5, 1, 0);
    run_op(32'h300, 32'd2, 12, 1);          // R1 ignored start
    run_op(32'hFFFF_FFF0, 32'd7, 8, 0);     // R2 wrap
    for (int r = 0; r < 20; r++) begin
      logic [31:0] st;
      case ($urandom % 4)
        0: st = 32'($urandom % 5);
        1: st = 32'(($urandom % 4) * 16);
        2: st = -32'($urandom % 9);
        default: st = $urandom;
      endcase
      run_op($urandom, st, int'($urandom % 80), 0);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule